// File: doc/BRIEF.md
# Wide Instruction Fetch and Slot Expander

This block sits at the front of a very-long-instruction-word core. It reads a program memory 128 bits at a time. It finds instruction boundaries in a byte stream whose instructions come in five lengths, and it issues one fully expanded seven-slot bundle per clock. Each bundle carries its own slot payloads and a valid bit for each slot. Shorter encodings carry only a fixed subset of the slots. The expander places each carried field on its slot output and drives every slot the encoding lacks as an all-zero NOP with its valid bit low.

The seven slots always appear in the same order:

| Index | Slot |
|---|---|
| 0 | vector load, unit A |
| 1 | vector load, unit B |
| 2 | store |
| 3 | scalar operation |
| 4 | move 0 |
| 5 | move 1 |
| 6 | vector operation |

Slots 0 to 5 are 12 bits wide and slot 6 is 32 bits wide.

Fetch is unaligned. A two-word realignment buffer lets an instruction that crosses a 16-byte boundary be assembled before it is decoded. A redirect flushes that buffer and restarts fetch at any even byte address. A stall freezes the issue stage.

Top module: `vliw_fetch_expand`

## Requirements
- R1: After synchronous reset, `o_issue`, `o_pc`, `o_len`, `o_slot_vld` and every slot payload are zero, and the first instruction issued is the one at byte address 0.
- R2: The length code is bits [2:0] of the instruction's first byte (bit 3 is reserved). The codes map to lengths as follows: 0 gives 2 bytes, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 16. Codes 5, 6 and 7 are treated as 2-byte instructions with no slots. `o_len` reports the issued instruction's length in bytes.
- R3: Carried slots are packed in increasing slot index from bit 4 upward, with no gaps.
  - Code 1 carries the scalar slot at [15:4] and move 0 at [27:16].
  - Code 2 carries load A at [15:4], load B at [27:16] and the vector slot at [59:28].
  - Code 3 carries load A [15:4], load B [27:16], store [39:28], move 0 [51:40] and vector [83:52].
  - Code 4 carries all seven slots at [15:4], [27:16], [39:28], [51:40], [63:52], [75:64] and [107:76].
- R4: A slot the format does not carry is output as zero, with its bit of `o_slot_vld` low (bit i belongs to slot i). Unused bits of an instruction never reach any output.
- R5: The internal program counter advances by the instruction length. It wraps modulo the program memory size (16 kB by default). `o_pc` gives the byte address of the issued instruction.
- R6: Instructions that straddle 16-byte fetch words, including a straddle across the top of memory, issue intact, in program order, with none lost or repeated. At most one instruction issues per cycle.
- R7: A redirect produces a bubble (`o_issue` low, all slots NOP) on the next cycle. The first instruction issued afterwards is the one at the target, which may be any even address. No instruction from the old path issues after the redirect, and the redirect takes priority over stall.
- R8: While `stall` is high and `redirect` is low, every output holds its value, and the instruction stream resumes afterwards without loss or duplication.
- R9: A run of 16-byte instructions starting at a 16-byte aligned address issues on consecutive cycles once its first instruction has issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze issue stage and program counter |
| redirect | input | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | input | 14 | Byte target of the redirect (bit 0 ignored) |
| pmem_req | output | 1 | Program memory read request |
| pmem_addr | output | 10 | Program memory word address (16-byte words) |
| pmem_rdata | input | 128 | Read data, valid the cycle after the request |
| o_issue | output | 1 | An expanded instruction is on the outputs |
| o_pc | output | 14 | Byte address of the issued instruction |
| o_len | output | 5 | Length of the issued instruction in bytes |
| o_slot_vld | output | 7 | Per-slot valid, bit i for slot i |
| o_lda | output | 12 | Vector load A slot |
| o_ldb | output | 12 | Vector load B slot |
| o_st | output | 12 | Store slot |
| o_alu | output | 12 | Scalar slot |
| o_mv0 | output | 12 | Move slot 0 |
| o_mv1 | output | 12 | Move slot 1 |
| o_vec | output | 32 | Vector operation slot |

## Verification
The bench targets the cases that stress the realignment buffer:
- **Word straddles:** instructions that cross a word boundary and one that crosses the top of memory. A wrong byte shift would corrupt fields or repeat bytes.
- **Reserved length codes with junk bits:** a decoder that trusts those codes would emit garbage slots or step the counter wrongly.
- **Mid-stream redirect to an odd half-word:** a design that forgot to flush, or to drop the in-flight word, would issue an instruction from the old path.
- **Stall:** a stall that froze only the outputs and not the buffer would skip instructions.
- **Throughput:** a back-to-back run of full instructions shows whether the fetch throttle is too cautious to sustain one bundle per clock.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    localparam int NSLOT     = 7;
    localparam int HDR_W     = 4;
    localparam int WORD_W    = 128;
    localparam int WORD_B    = WORD_W / 8;
    localparam int SW_NARROW = 12;
    localparam int SW_VEC    = 32;

    // slot indices in fixed bundle order
    localparam int SL_LDA = 0;
    localparam int SL_LDB = 1;
    localparam int SL_ST  = 2;
    localparam int SL_ALU = 3;
    localparam int SL_MV0 = 4;
    localparam int SL_MV1 = 5;
    localparam int SL_VEC = 6;

    typedef enum logic [2:0] {
        FMT_P16  = 3'd0,
        FMT_P32  = 3'd1,
        FMT_P64  = 3'd2,
        FMT_P96  = 3'd3,
        FMT_P128 = 3'd4
    } fmt_e;

    function automatic int slot_w(int s);
        return (s == SL_VEC) ? SW_VEC : SW_NARROW;
    endfunction

    // reserved codes fall back to the 2-byte empty format
    function automatic fmt_e fmt_of(logic [2:0] code);
        case (code)
            3'd1:    return FMT_P32;
            3'd2:    return FMT_P64;
            3'd3:    return FMT_P96;
            3'd4:    return FMT_P128;
            default: return FMT_P16;
        endcase
    endfunction

    function automatic logic [4:0] fmt_bytes(fmt_e f);
        case (f)
            FMT_P32:  return 5'd4;
            FMT_P64:  return 5'd8;
            FMT_P96:  return 5'd12;
            FMT_P128: return 5'd16;
            default:  return 5'd2;
        endcase
    endfunction

    // which slots each format carries, bit i = slot i
    function automatic logic [NSLOT-1:0] fmt_mask(fmt_e f);
        case (f)
            FMT_P32:  return 7'b0011000;
            FMT_P64:  return 7'b1000011;
            FMT_P96:  return 7'b1010111;
            FMT_P128: return 7'b1111111;
            default:  return 7'b0000000;
        endcase
    endfunction

    // carried slots are packed upward after the header, in slot order
    function automatic int slot_off(fmt_e f, int s);
        logic [NSLOT-1:0] m;
        int off;
        m   = fmt_mask(f);
        off = HDR_W;
        for (int i = 0; i < s; i++) begin
            if (m[i]) off += slot_w(i);
        end
        return off;
    endfunction

endpackage

// File: rtl/ifx_fetch_ctl.sv
module ifx_fetch_ctl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_word,
    input  logic              room,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              rsp_vld
);

    // no request in a redirect cycle, so nothing stale lands afterwards
    assign req = room && !redirect;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            rsp_vld <= 1'b0;
        end else begin
            rsp_vld <= req;
            if (redirect)
                addr <= redirect_word;
            else if (req)
                addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/ifx_realign.sv
module ifx_realign
    import ifx_pkg::*;
#(
    parameter int BUF_B = 2 * WORD_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [3:0]        flush_skip,
    input  logic              rsp_vld,
    input  logic [WORD_W-1:0] rsp_data,
    input  logic [4:0]        consume,
    output logic [WORD_W-1:0] head,
    output logic [$clog2(BUF_B+1)-1:0] cnt,
    output logic              room
);

    localparam int BUF_W = BUF_B * 8;
    localparam int CNT_W = $clog2(BUF_B + 1);

    logic [BUF_W-1:0] buf_q, buf_d, shifted, incoming;
    logic [CNT_W-1:0] cnt_q, cnt_d, keep, in_bytes;
    logic [3:0]       skip_q;

    assign keep     = cnt_q - CNT_W'(consume);
    assign in_bytes = rsp_vld ? (CNT_W'(WORD_B) - CNT_W'(skip_q)) : '0;
    assign shifted  = buf_q >> {consume, 3'b000};
    assign incoming = {{(BUF_W-WORD_W){1'b0}}, rsp_data >> {skip_q, 3'b000}};

    always_comb begin
        buf_d = shifted;
        if (rsp_vld) buf_d = shifted | (incoming << {keep, 3'b000});
        cnt_d = keep + in_bytes;
    end

    assign room = cnt_d <= CNT_W'(WORD_B);
    assign head = buf_q[WORD_W-1:0];
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            skip_q <= '0;
        end else if (flush) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            skip_q <= flush_skip;
        end else begin
            buf_q <= buf_d;
            cnt_q <= cnt_d;
            if (rsp_vld) skip_q <= '0;
        end
    end

    // R6: the buffer never holds more than its capacity
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BUF_B));

    // R6: an arriving word always finds room behind the kept bytes
    a_r6_room_on_arrival: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !flush) |-> (keep <= CNT_W'(WORD_B)));

endmodule

// File: rtl/ifx_expand.sv
module ifx_expand
    import ifx_pkg::*;
(
    input  logic [WORD_W-1:0]                word,
    input  fmt_e                             fmt,
    output logic [NSLOT-1:0]                 vld,
    output logic [NSLOT-2:0][SW_NARROW-1:0]  nar,
    output logic [SW_VEC-1:0]                vec
);

    assign vld = fmt_mask(fmt);

    for (genvar s = 0; s < NSLOT - 1; s++) begin : g_nar
        logic [SW_NARROW-1:0] field;
        always_comb begin
            logic [NSLOT-1:0] m;
            m     = fmt_mask(fmt);
            field = '0;
            if (m[s]) field = SW_NARROW'(word >> slot_off(fmt, s));
        end
        assign nar[s] = field;
    end

    always_comb begin
        logic [NSLOT-1:0] m;
        m   = fmt_mask(fmt);
        vec = '0;
        if (m[SL_VEC]) vec = SW_VEC'(word >> slot_off(fmt, SL_VEC));
    end

endmodule

// File: rtl/vliw_fetch_expand.sv
module vliw_fetch_expand
    import ifx_pkg::*;
#(
    parameter int PMEM_BYTES = 16384
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          stall,
    input  logic                          redirect,
    input  logic [$clog2(PMEM_BYTES)-1:0] redirect_pc,
    output logic                          pmem_req,
    output logic [$clog2(PMEM_BYTES)-$clog2(WORD_B)-1:0] pmem_addr,
    input  logic [WORD_W-1:0]             pmem_rdata,
    output logic                          o_issue,
    output logic [$clog2(PMEM_BYTES)-1:0] o_pc,
    output logic [4:0]                    o_len,
    output logic [NSLOT-1:0]              o_slot_vld,
    output logic [SW_NARROW-1:0]          o_lda,
    output logic [SW_NARROW-1:0]          o_ldb,
    output logic [SW_NARROW-1:0]          o_st,
    output logic [SW_NARROW-1:0]          o_alu,
    output logic [SW_NARROW-1:0]          o_mv0,
    output logic [SW_NARROW-1:0]          o_mv1,
    output logic [SW_VEC-1:0]             o_vec
);

    localparam int PC_W   = $clog2(PMEM_BYTES);
    localparam int OFF_W  = $clog2(WORD_B);
    localparam int ADDR_W = PC_W - OFF_W;
    localparam int BUF_B  = 2 * WORD_B;
    localparam int CNT_W  = $clog2(BUF_B + 1);

    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  cnt;
    logic              room, rsp_vld, ready, fire;
    logic [4:0]        len, consume;
    logic [3:0]        skip;
    fmt_e              fmt;

    logic [NSLOT-1:0]                vld_x;
    logic [NSLOT-2:0][SW_NARROW-1:0] nar_x, nar_q;
    logic [SW_VEC-1:0]               vec_x, vec_q;

    assign fmt     = fmt_of(head[2:0]);
    assign len     = fmt_bytes(fmt);
    assign ready   = (cnt >= CNT_W'(2)) && (cnt >= CNT_W'(len));
    assign fire    = ready && !stall && !redirect;
    assign consume = fire ? len : 5'd0;
    assign skip    = {redirect_pc[OFF_W-1:1], 1'b0};

    ifx_fetch_ctl #(.ADDR_W(ADDR_W)) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .redirect      (redirect),
        .redirect_word (redirect_pc[PC_W-1:OFF_W]),
        .room          (room),
        .req           (pmem_req),
        .addr          (pmem_addr),
        .rsp_vld       (rsp_vld)
    );

    ifx_realign #(.BUF_B(BUF_B)) u_align (
        .clk        (clk),
        .rst        (rst),
        .flush      (redirect),
        .flush_skip (skip),
        .rsp_vld    (rsp_vld),
        .rsp_data   (pmem_rdata),
        .consume    (consume),
        .head       (head),
        .cnt        (cnt),
        .room       (room)
    );

    ifx_expand u_exp (
        .word (head),
        .fmt  (fmt),
        .vld  (vld_x),
        .nar  (nar_x),
        .vec  (vec_x)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (redirect) begin
            pc_q <= {redirect_pc[PC_W-1:1], 1'b0};
        end else if (fire) begin
            pc_q <= pc_q + PC_W'(len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || redirect) begin
            o_issue    <= 1'b0;
            o_pc       <= '0;
            o_len      <= '0;
            o_slot_vld <= '0;
            nar_q      <= '0;
            vec_q      <= '0;
        end else if (!stall) begin
            o_issue    <= fire;
            o_pc       <= fire ? pc_q : '0;
            o_len      <= fire ? len : 5'd0;
            o_slot_vld <= fire ? vld_x : '0;
            nar_q      <= fire ? nar_x : '0;
            vec_q      <= fire ? vec_x : '0;
        end
    end

    assign o_lda = nar_q[SL_LDA];
    assign o_ldb = nar_q[SL_LDB];
    assign o_st  = nar_q[SL_ST];
    assign o_alu = nar_q[SL_ALU];
    assign o_mv0 = nar_q[SL_MV0];
    assign o_mv1 = nar_q[SL_MV1];
    assign o_vec = vec_q;

    // R8: stall without redirect freezes the issue stage
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !redirect) |=> ($stable(o_issue) && $stable(o_pc) && $stable(o_len)
                                  && $stable(o_slot_vld) && $stable(o_vec) && $stable(o_lda)));

    // R7: the cycle after a redirect is a bubble
    a_r7_redirect_bubble: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!o_issue && (o_slot_vld == '0)));

    // R2: only the five legal lengths are ever reported
    a_r2_len_legal: assert property (@(posedge clk) disable iff (rst)
        o_issue |-> (o_len inside {5'd2, 5'd4, 5'd8, 5'd12, 5'd16}));

    // R4: no valid slot without an issued instruction; absent slots carry zero
    a_r4_no_vld_idle: assert property (@(posedge clk) disable iff (rst)
        !o_issue |-> (o_slot_vld == '0));
    a_r4_vec_nop: assert property (@(posedge clk) disable iff (rst)
        !o_slot_vld[SL_VEC] |-> (o_vec == '0));
    a_r4_lda_nop: assert property (@(posedge clk) disable iff (rst)
        !o_slot_vld[SL_LDA] |-> (o_lda == '0));

    // R5: issued addresses are always half-word aligned
    a_r5_pc_even: assert property (@(posedge clk) disable iff (rst)
        o_issue |-> !o_pc[0]);

endmodule

// File: tb/sim_vliw_fetch_expand.sv
module sim_vliw_fetch_expand;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stall = 1'b0;
    logic         redirect = 1'b0;
    logic [13:0]  redirect_pc = '0;
    logic         pmem_req;
    logic [9:0]   pmem_addr;
    logic [127:0] pmem_rdata = '0;
    logic         o_issue;
    logic [13:0]  o_pc;
    logic [4:0]   o_len;
    logic [6:0]   o_slot_vld;
    logic [11:0]  o_lda, o_ldb, o_st, o_alu, o_mv0, o_mv1;
    logic [31:0]  o_vec;

    always #5 clk = ~clk;

    vliw_fetch_expand u0 (
        .clk(clk), .rst(rst), .stall(stall), .redirect(redirect),
        .redirect_pc(redirect_pc), .pmem_req(pmem_req), .pmem_addr(pmem_addr),
        .pmem_rdata(pmem_rdata), .o_issue(o_issue), .o_pc(o_pc), .o_len(o_len),
        .o_slot_vld(o_slot_vld), .o_lda(o_lda), .o_ldb(o_ldb), .o_st(o_st),
        .o_alu(o_alu), .o_mv0(o_mv0), .o_mv1(o_mv1), .o_vec(o_vec)
    );

    // program memory with one cycle of read latency
    logic [127:0] mem [1024];
    always @(posedge clk) if (pmem_req) pmem_rdata <= mem[pmem_addr];

    int checks = 0, fails = 0, got = 0, exp_cnt = 0, uid = 0, wr_ptr = 0;
    bit mon_on = 0, finished = 0;
    logic [13:0]  e_pc  [64];
    logic [4:0]   e_len [64];
    logic [6:0]   e_msk [64];
    logic [103:0] e_pay [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [103:0] out_pay();
        return {o_vec, o_mv1, o_mv0, o_alu, o_st, o_ldb, o_lda};
    endfunction

    function automatic logic [31:0] sval(int idx, int s);
        return 32'(idx * 40503 + s * 9973 + 12345) ^ 32'h5A5A0000;
    endfunction

    task automatic put_byte(input int a, input logic [7:0] b);
        int w;
        w = (a % 16384) / 16;
        mem[w][(a % 16) * 8 +: 8] = b;
    endtask

    // encode one instruction with the field layout of R2/R3 and record it
    task automatic add_instr(input int code);
        logic [127:0] w;
        logic [31:0]  v [7];
        logic [6:0]   m;
        int nb;
        for (int s = 0; s < 7; s++) v[s] = sval(uid, s);
        w = '0;
        case (code)
            1: begin m = 7'b0011000; nb = 4;
                w[15:4] = v[3][11:0]; w[27:16] = v[4][11:0]; w[31:28] = 4'hF; end
            2: begin m = 7'b1000011; nb = 8;
                w[15:4] = v[0][11:0]; w[27:16] = v[1][11:0]; w[59:28] = v[6];
                w[63:60] = 4'hA; end
            3: begin m = 7'b1010111; nb = 12;
                w[15:4] = v[0][11:0]; w[27:16] = v[1][11:0]; w[39:28] = v[2][11:0];
                w[51:40] = v[4][11:0]; w[83:52] = v[6]; w[95:84] = 12'hC3C; end
            4: begin m = 7'b1111111; nb = 16;
                w[15:4] = v[0][11:0]; w[27:16] = v[1][11:0]; w[39:28] = v[2][11:0];
                w[51:40] = v[3][11:0]; w[63:52] = v[4][11:0]; w[75:64] = v[5][11:0];
                w[107:76] = v[6]; w[127:108] = 20'hBEEF1; end
            default: begin m = 7'b0000000; nb = 2; w[15:4] = 12'hABC; end
        endcase
        w[2:0] = 3'(code);
        w[3] = 1'b0;
        for (int i = 0; i < nb; i++) put_byte(wr_ptr + i, w[i*8 +: 8]);
        e_pc[exp_cnt]  = 14'(wr_ptr % 16384);
        e_len[exp_cnt] = 5'(nb);
        e_msk[exp_cnt] = m;
        e_pay[exp_cnt] = {m[6] ? v[6] : 32'h0,
                          m[5] ? v[5][11:0] : 12'h0, m[4] ? v[4][11:0] : 12'h0,
                          m[3] ? v[3][11:0] : 12'h0, m[2] ? v[2][11:0] : 12'h0,
                          m[1] ? v[1][11:0] : 12'h0, m[0] ? v[0][11:0] : 12'h0};
        exp_cnt++;
        uid++;
        wr_ptr = (wr_ptr + nb) % 16384;
    endtask

    // monitor: samples 2 ns after each rising edge
    logic         h_issue;
    logic [13:0]  h_pc;
    logic [4:0]   h_len;
    logic [6:0]   h_vld;
    logic [103:0] h_pay;
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (redirect) begin
                    chk(!o_issue && o_slot_vld == 0, "R7", "bubble after redirect",
                        {o_issue, o_slot_vld}, 0);
                    got = 0;
                end else if (stall) begin
                    chk({o_issue, o_pc, o_len, o_slot_vld, out_pay()} ==
                        {h_issue, h_pc, h_len, h_vld, h_pay}, "R8", "hold under stall",
                        {o_issue, o_pc, o_len, o_slot_vld, out_pay()},
                        {h_issue, h_pc, h_len, h_vld, h_pay});
                end else if (o_issue && mon_on && got < exp_cnt) begin
                    chk(o_pc == e_pc[got], "R5", "issued pc", o_pc, e_pc[got]);
                    chk(o_len == e_len[got], "R2", "length", o_len, e_len[got]);
                    chk(o_slot_vld == e_msk[got], "R4", "slot valid", o_slot_vld, e_msk[got]);
                    chk(out_pay() == e_pay[got], "R3", "slot payloads", out_pay(), e_pay[got]);
                    got++;
                end
                if (!stall) begin
                    h_issue = o_issue; h_pc = o_pc; h_len = o_len;
                    h_vld = o_slot_vld; h_pay = out_pay();
                end
            end
        end
    end

    task automatic do_redirect(input int target, input bit mon);
        @(negedge clk);
        redirect = 1'b1;
        redirect_pc = 14'(target);
        mon_on = mon;
        @(negedge clk);
        redirect = 1'b0;
    endtask

    task automatic wait_done(input string req, input int limit);
        int n = 0;
        while (got < exp_cnt && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(got == exp_cnt, req, "all instructions issued in order", got, exp_cnt);
    endtask

    task automatic build_prog1();
        int codes [18] = '{4, 1, 0, 3, 2, 4, 5, 3, 1, 2, 4, 4, 3, 0, 7, 2, 1, 4};
        exp_cnt = 0;
        wr_ptr = 0;
        foreach (codes[i]) add_instr(codes[i]);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        build_prog1();
        mon_on = 1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #3;
        // R1: outputs are all zero right after reset
        chk({o_issue, o_pc, o_len, o_slot_vld, out_pay()} == 0, "R1", "reset outputs",
            {o_issue, o_pc, o_len, o_slot_vld, out_pay()}, 0);
    endtask

    // R1/R6: first program runs from address 0 with straddles and reserved codes
    task automatic t_stream();
        wait_done("R6", 300);
    endtask

    // R8: stall mid-stream, then resume without loss
    task automatic t_stall();
        do_redirect(0, 1);
        repeat (6) @(negedge clk);
        stall = 1'b1;
        repeat (4) @(negedge clk);
        stall = 1'b0;
        wait_done("R8", 300);
    endtask

    // R7: redirect to an unaligned target while another path is running
    task automatic t_redirect_mid();
        int codes [7] = '{3, 4, 1, 2, 0, 4, 3};
        mon_on = 0;
        exp_cnt = 0;
        wr_ptr = 14'h1A6;
        foreach (codes[i]) add_instr(codes[i]);
        do_redirect(0, 0);
        repeat (5) @(negedge clk);
        do_redirect(14'h1A6, 1);
        wait_done("R7", 300);
    endtask

    // R9: aligned full-length run issues every cycle
    task automatic t_burst();
        int n = 0;
        mon_on = 0;
        exp_cnt = 0;
        wr_ptr = 14'h800;
        for (int i = 0; i < 6; i++) add_instr(4);
        do_redirect(14'h800, 1);
        while (!o_issue && n < 50) begin
            @(posedge clk);
            #3;
            n++;
        end
        chk(o_issue, "R9", "first of burst issued", o_issue, 1);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #3;
            chk(o_issue, "R9", "back-to-back issue", o_issue, 1);
        end
        wait_done("R9", 50);
    endtask

    // R5/R6: program straddles the top of memory and wraps to 0
    task automatic t_wrap();
        mon_on = 0;
        exp_cnt = 0;
        wr_ptr = 14'h3FF2;
        add_instr(3);
        add_instr(2);
        add_instr(1);
        add_instr(4);
        do_redirect(14'h3FF2, 1);
        wait_done("R5", 100);
        chk(e_pc[1] == 14'h3FFE && e_pc[2] == 14'h0006, "R5", "wrap addresses in plan",
            {e_pc[1], e_pc[2]}, {14'h3FFE, 14'h0006});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stream();
        t_stall();
        t_redirect_mid();
        t_burst();
        t_wrap();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule